// File: doc/BRIEF.md
# Labelled Block Multiplexer Transmitter

This block merges three independent serial bit streams into a single serial output built from equal-length labelled blocks. Each source delivers bits through its own enable strobe, sampled on the system clock. A source owns a pair of payload banks. One bank collects incoming bits while the other, once full, waits to be copied into the output path. A copy engine moves whole blocks, each prefixed with the source's label, into a three-entry ring of output block registers. It moves one bit per system clock. The serializer drains the ring in order, one bit per output strobe.

Blocks leave in the order they were copied, not in a fixed source rotation. A five-step strobe scan picks the next block: a dead step, then sources 1, 2 and 3 in falling priority, then the filler step. The filler step loads a synchronization block when the ring is about to run dry. An optional block counter forces a synchronization block at a fixed interval. All labels and synchronization fields are configuration inputs and are expected to be held steady during operation.

Top module: `blkmux_tx`

## Requirements
- R1: Every output block is 104 bits, shifted out most significant bit first, one bit per `out_en` pulse. A data block is the source's 8-bit label followed by 96 payload bits, with the payload bit received first sent first.
- R2: A synchronization block carries, in transmit order, `sync_label`, the 24-bit `sync_pattern`, `sync_src`, `sync_dst`, `sync_fmt` and the 48 bits of `sync_aux`.
- R3: After reset, `ovf_flags` is 0, `ser_out` presents the top bit of `sync_label`, and output block 0 is a synchronization block. With no source data, every output block is a synchronization block.
- R4: Each source alternates between its two banks. While no overflow occurs, every block of a source is delivered exactly once, in the order received.
- R5: When several sources hold a full bank at the start of a scan, source 1 is copied before source 2, and source 2 before source 3.
- R6: No copy ever writes the ring entry that the serializer is reading. A copy waits until that entry has been released.
- R7: When `out_en` pulses no more often than every second clock, the next ring entry is always filled before the serializer reaches it. A synchronization block fills in whenever no source is ready and only one entry is left. Every output block therefore carries a valid label.
- R8: With `sync_every` = P > 0, output block k (k ≥ 1, the block present at reset being block 0) is a synchronization block whenever k mod P = 0. When this applies, no source is granted. `sync_every` = 0 disables the forcing.
- R9: If a source completes a bank while its other bank is still waiting, the new bank is discarded and `ovf_flags` bit c-1 is set for source c. The bit stays set until reset, and the other sources are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the copy clock |
| rst | input | 1 | Synchronous active-high reset |
| src_en | input | 3 | Per-source bit strobe (bit 0 = source 1) |
| src_bit | input | 3 | Per-source serial data, taken when its strobe is high |
| src_labels | input | 24 | Source labels; bits 7:0 source 1, 15:8 source 2, 23:16 source 3 |
| sync_label | input | 8 | Label of synchronization blocks |
| sync_pattern | input | 24 | Synchronization pattern |
| sync_src | input | 8 | Source identification word |
| sync_dst | input | 8 | Destination word |
| sync_fmt | input | 8 | Format word |
| sync_aux | input | 48 | Auxiliary or fill bits of synchronization blocks |
| sync_every | input | 8 | Forced synchronization interval in blocks; 0 = off |
| out_en | input | 1 | Output bit strobe |
| ser_out | output | 1 | Current output bit |
| ovf_flags | output | 3 | Sticky per-source overflow flags |

## Verification
The assertions check, on every cycle, the local safety rules: a copy never targets the entry being read, and the next entry is never empty when a block ends. They also check that a bank is released only while it is ready, that a source grant goes only to a ready source, that a forced interval grants the synchronization source, and that overflow flags never clear. Only the bench scenarios can show end-to-end content. These are the exact bit layout of both block kinds, the in-order and loss-free delivery of each source's payload, and the grant order when sources are ready together. They also cover the position of forced synchronization blocks in the stream and which block is dropped on overflow.

// File: rtl/blkmux_pkg.sv
package blkmux_pkg;
    localparam int NCH        = 3;
    localparam int LBL_W      = 8;
    localparam int PAT_W      = 24;
    localparam int SYNC_FIX_W = PAT_W + 3 * LBL_W;
    localparam int RING_N     = 3;
    localparam int PTR_W      = 2;

    typedef logic [PTR_W-1:0] ring_ptr_t;

    typedef enum logic [1:0] {
        SRC_CH0  = 2'd0,
        SRC_CH1  = 2'd1,
        SRC_CH2  = 2'd2,
        SRC_SYNC = 2'd3
    } src_t;

    typedef struct packed {
        logic [LBL_W-1:0] label;
        logic [PAT_W-1:0] pattern;
        logic [LBL_W-1:0] src_id;
        logic [LBL_W-1:0] dst_id;
        logic [LBL_W-1:0] fmt_id;
    } sync_hdr_t;

    function automatic ring_ptr_t ptr_inc(input ring_ptr_t p);
        return (p == ring_ptr_t'(RING_N - 1)) ? '0 : p + ring_ptr_t'(1);
    endfunction
endpackage

// File: rtl/blkmux_chan.sv
module blkmux_chan #(
    parameter int PAY_W = 96
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic             rel,
    output logic             rdy,
    output logic             ovf,
    output logic [PAY_W-1:0] rd_data
);
    localparam int CNT_W = $clog2(PAY_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PAY_W - 1);

    logic [PAY_W-1:0] bank [2];
    logic             wsel;
    logic [CNT_W-1:0] cnt;
    logic             fill_done;
    logic             rdy_keep;

    assign fill_done = bit_en && (cnt == CNT_LAST);
    assign rdy_keep  = rdy && !rel;
    assign rd_data   = bank[~wsel];

    always_ff @(posedge clk) begin
        if (rst) begin
            bank[0] <= '0;
            bank[1] <= '0;
            wsel    <= 1'b0;
            cnt     <= '0;
            rdy     <= 1'b0;
            ovf     <= 1'b0;
        end else begin
            if (bit_en) begin
                bank[wsel] <= {bank[wsel][PAY_W-2:0], bit_in};
                cnt        <= fill_done ? '0 : cnt + 1'b1;
            end
            if (fill_done && rdy_keep) begin
                ovf <= 1'b1;
                rdy <= 1'b1;
            end else if (fill_done) begin
                rdy  <= 1'b1;
                wsel <= ~wsel;
            end else begin
                rdy <= rdy_keep;
            end
        end
    end

    AST_RELEASE_READY: assert property (@(posedge clk) disable iff (rst) rel |-> rdy); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) ovf |=> ovf); // R9
endmodule

// File: rtl/blkmux_xfer.sv
module blkmux_xfer
    import blkmux_pkg::*;
#(
    parameter int BLK_W = 104,
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   ch_rdy,
    input  logic [BLK_W-1:0] ch_vec [NCH],
    input  logic [BLK_W-1:0] sync_vec,
    input  logic [PER_W-1:0] sync_every,
    input  ring_ptr_t        rd_ptr,
    output logic [NCH-1:0]   ch_rel,
    output ring_ptr_t        wr_ptr,
    output logic             busy,
    output logic [BLK_W-1:0] rd_word
);
    localparam int XC_W = $clog2(BLK_W);
    localparam logic [XC_W-1:0] XC_LAST = XC_W'(BLK_W - 1);
    localparam logic [2:0] SLOT_CLR  = 3'd0;
    localparam logic [2:0] SLOT_SYNC = 3'(NCH + 1);

    logic [BLK_W-1:0] ring [RING_N];
    logic [2:0]       slot;
    logic [XC_W-1:0]  xcnt;
    logic [PER_W-1:0] bcnt;
    src_t             sel;

    logic             last;
    logic             force_sync;
    logic             starve;
    logic             hold;
    logic [1:0]       scan_idx;
    logic             scan_hit;
    logic [BLK_W-1:0] src_vec;
    logic             src_bit;

    assign last       = busy && (xcnt == XC_LAST);
    assign force_sync = (sync_every != '0) && (bcnt == sync_every - PER_W'(1));
    assign starve     = (wr_ptr == ptr_inc(rd_ptr));
    assign hold       = (wr_ptr == rd_ptr);
    assign scan_idx   = 2'(slot - 3'd1);
    assign scan_hit   = (slot != SLOT_CLR) && (slot != SLOT_SYNC) && !force_sync && ch_rdy[scan_idx];
    assign src_vec    = (sel == SRC_SYNC) ? sync_vec : ch_vec[sel];
    assign src_bit    = src_vec[XC_LAST - xcnt];
    assign rd_word    = ring[rd_ptr];

    for (genvar c = 0; c < NCH; c++) begin : g_rel
        assign ch_rel[c] = last && (sel == src_t'(c));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot    <= SLOT_CLR;
            busy    <= 1'b0;
            xcnt    <= '0;
            bcnt    <= '0;
            sel     <= SRC_SYNC;
            wr_ptr  <= ring_ptr_t'(1);
            ring[0] <= sync_vec;
            for (int i = 1; i < RING_N; i++) ring[i] <= '0;
        end else if (busy) begin
            ring[wr_ptr] <= {ring[wr_ptr][BLK_W-2:0], src_bit};
            if (last) begin
                busy   <= 1'b0;
                xcnt   <= '0;
                wr_ptr <= ptr_inc(wr_ptr);
                bcnt   <= force_sync ? '0 : bcnt + PER_W'(1);
                slot   <= SLOT_CLR;
            end else begin
                xcnt <= xcnt + 1'b1;
            end
        end else if (hold) begin
            slot <= SLOT_CLR;
        end else if (slot == SLOT_CLR) begin
            slot <= slot + 3'd1;
        end else if (slot == SLOT_SYNC) begin
            if (force_sync || starve) begin
                busy <= 1'b1;
                sel  <= SRC_SYNC;
            end
            slot <= SLOT_CLR;
        end else if (scan_hit) begin
            busy <= 1'b1;
            sel  <= src_t'(scan_idx);
            slot <= SLOT_CLR;
        end else begin
            slot <= slot + 3'd1;
        end
    end

    AST_START_READY: assert property (@(posedge clk) disable iff (rst)
        (busy && xcnt == '0 && sel != SRC_SYNC) |-> ch_rdy[sel]); // R5
    AST_FORCED_SYNC: assert property (@(posedge clk) disable iff (rst)
        (busy && xcnt == '0 && force_sync) |-> (sel == SRC_SYNC)); // R8
endmodule

// File: rtl/blkmux_ser.sv
module blkmux_ser
    import blkmux_pkg::*;
#(
    parameter int BLK_W = 104
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             out_en,
    input  logic [BLK_W-1:0] word,
    output ring_ptr_t        rd_ptr,
    output logic             bit_out,
    output logic             blk_last
);
    localparam int OC_W = $clog2(BLK_W);
    localparam logic [OC_W-1:0] OC_LAST = OC_W'(BLK_W - 1);

    logic [OC_W-1:0] oc;

    assign bit_out  = word[OC_LAST - oc];
    assign blk_last = (oc == OC_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            oc     <= '0;
            rd_ptr <= '0;
        end else if (out_en) begin
            if (blk_last) begin
                oc     <= '0;
                rd_ptr <= ptr_inc(rd_ptr);
            end else begin
                oc <= oc + 1'b1;
            end
        end
    end
endmodule

// File: rtl/blkmux_tx.sv
module blkmux_tx
    import blkmux_pkg::*;
#(
    parameter int PAY_W = 96,
    parameter int PER_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NCH-1:0]              src_en,
    input  logic [NCH-1:0]              src_bit,
    input  logic [NCH*LBL_W-1:0]        src_labels,
    input  logic [LBL_W-1:0]            sync_label,
    input  logic [PAT_W-1:0]            sync_pattern,
    input  logic [LBL_W-1:0]            sync_src,
    input  logic [LBL_W-1:0]            sync_dst,
    input  logic [LBL_W-1:0]            sync_fmt,
    input  logic [PAY_W-SYNC_FIX_W-1:0] sync_aux,
    input  logic [PER_W-1:0]            sync_every,
    input  logic                        out_en,
    output logic                        ser_out,
    output logic [NCH-1:0]              ovf_flags
);
    localparam int BLK_W = LBL_W + PAY_W;

    sync_hdr_t        hdr;
    logic [BLK_W-1:0] sync_vec;
    logic [BLK_W-1:0] ch_vec [NCH];
    logic [NCH-1:0]   ch_rdy;
    logic [NCH-1:0]   ch_rel;
    ring_ptr_t        wr_ptr;
    ring_ptr_t        rd_ptr;
    logic             xfer_busy;
    logic [BLK_W-1:0] rd_word;
    logic             blk_last;

    assign hdr      = '{label: sync_label, pattern: sync_pattern, src_id: sync_src,
                        dst_id: sync_dst, fmt_id: sync_fmt};
    assign sync_vec = {hdr, sync_aux};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [PAY_W-1:0] pay;
        blkmux_chan #(.PAY_W(PAY_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .bit_en  (src_en[c]),
            .bit_in  (src_bit[c]),
            .rel     (ch_rel[c]),
            .rdy     (ch_rdy[c]),
            .ovf     (ovf_flags[c]),
            .rd_data (pay)
        );
        assign ch_vec[c] = {src_labels[c*LBL_W +: LBL_W], pay};
    end

    blkmux_xfer #(.BLK_W(BLK_W), .PER_W(PER_W)) u_xfer (
        .clk        (clk),
        .rst        (rst),
        .ch_rdy     (ch_rdy),
        .ch_vec     (ch_vec),
        .sync_vec   (sync_vec),
        .sync_every (sync_every),
        .rd_ptr     (rd_ptr),
        .ch_rel     (ch_rel),
        .wr_ptr     (wr_ptr),
        .busy       (xfer_busy),
        .rd_word    (rd_word)
    );

    blkmux_ser #(.BLK_W(BLK_W)) u_ser (
        .clk      (clk),
        .rst      (rst),
        .out_en   (out_en),
        .word     (rd_word),
        .rd_ptr   (rd_ptr),
        .bit_out  (ser_out),
        .blk_last (blk_last)
    );

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        xfer_busy |-> (wr_ptr != rd_ptr)); // R6
    AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
        (out_en && blk_last) |-> (wr_ptr != ptr_inc(rd_ptr))); // R7
endmodule

// File: tb/blkmux_tx_tb.sv
module blkmux_tx_tb;
    localparam logic [7:0]  SLBL = 8'h01;
    localparam logic [23:0] SPAT = 24'hFAF320;
    localparam logic [7:0]  SSRC = 8'h5A, SDST = 8'h33, SFMT = 8'hC1;
    localparam logic [47:0] SAUX = 48'h0123_4567_89AB;
    localparam logic [7:0]  L1 = 8'h3C, L2 = 8'hC5, L3 = 8'h6A;
    localparam logic [103:0] SYNC_BLK = {SLBL, SPAT, SSRC, SDST, SFMT, SAUX};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   src_en = '0;
    logic [2:0]   src_bit = '0;
    logic [7:0]   sync_every = '0;
    logic         out_en = 1'b0;
    logic         ser_out;
    logic [2:0]   ovf_flags;

    int checks = 0;
    int fails = 0;
    logic         out_run = 1'b0;
    logic         phase = 1'b0;
    logic [103:0] cap [64];
    int           ncap = 0;
    int           nbit = 0;
    logic [103:0] shreg = '0;

    always #10 clk = ~clk;

    blkmux_tx u_dut (
        .clk(clk), .rst(rst), .src_en(src_en), .src_bit(src_bit),
        .src_labels({L3, L2, L1}), .sync_label(SLBL), .sync_pattern(SPAT),
        .sync_src(SSRC), .sync_dst(SDST), .sync_fmt(SFMT), .sync_aux(SAUX),
        .sync_every(sync_every), .out_en(out_en), .ser_out(ser_out),
        .ovf_flags(ovf_flags)
    );

    function automatic logic [95:0] exp_pay(input int c, input int n);
        logic [15:0] w;
        w = 16'(c * 4099 + n * 257 + 1);
        return {8'(8'hA0 + c), 8'(n), {5{w}}};
    endfunction

    function automatic logic [7:0] lbl_of(input int c);
        return (c == 0) ? L1 : (c == 1) ? L2 : L3;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [103:0] act, input logic [103:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // output capture: one out_en pulse every second clock
    initial begin
        forever begin
            @(negedge clk);
            if (out_run && !rst && phase) begin
                shreg = {shreg[102:0], ser_out};
                nbit++;
                if (nbit == 104) begin
                    if (ncap < 64) cap[ncap] = shreg;
                    ncap++;
                    nbit = 0;
                end
                out_en = 1'b1;
            end else begin
                out_en = 1'b0;
            end
            phase = ~phase;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic do_reset(input logic [7:0] per);
        out_run = 1'b0;
        repeat (3) @(negedge clk);
        sync_every = per;
        src_en = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        ncap = 0;
        nbit = 0;
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic feed(input logic [2:0] mask, input int base, input int nblk, input int step);
        for (int i = 0; i < nblk * 96; i++) begin
            @(negedge clk);
            for (int c = 0; c < 3; c++) begin
                logic [95:0] p;
                p = exp_pay(c, base + i / 96);
                src_bit[c] = p[95 - (i % 96)];
            end
            src_en = mask;
            @(negedge clk);
            src_en = '0;
            repeat (step - 2) @(negedge clk);
        end
    endtask

    task automatic wait_blocks(input int n);
        while (ncap < n) @(negedge clk);
    endtask

    // walks the captured stream; checks layout, order, count and forced positions
    task automatic analyse(input int nexp, input int per);
        int seen [3];
        for (int c = 0; c < 3; c++) seen[c] = 0;
        for (int k = 0; k < ncap && k < 64; k++) begin
            logic [7:0] lab;
            logic       hit;
            lab = cap[k][103:96];
            hit = 1'b0;
            if (per != 0 && k > 0 && (k % per) == 0)
                check(lab == SLBL, "R8 forced sync position", {96'd0, lab}, {96'd0, SLBL});
            if (lab == SLBL) begin
                check(cap[k] == SYNC_BLK, "R2 sync block layout", cap[k], SYNC_BLK);
                hit = 1'b1;
            end
            for (int c = 0; c < 3; c++) begin
                if (lab == lbl_of(c)) begin
                    check(cap[k][95:0] == exp_pay(c, seen[c]), "R4 R1 payload order",
                          cap[k], {lbl_of(c), exp_pay(c, seen[c])});
                    seen[c]++;
                    hit = 1'b1;
                end
            end
            if (!hit) check(1'b0, "R7 block label valid", {96'd0, lab}, {96'd0, SLBL});
        end
        for (int c = 0; c < 3; c++)
            check(seen[c] == nexp, "R4 blocks delivered per source", 104'(seen[c]), 104'(nexp));
    endtask

    initial begin
        // T1: reset state and idle stream
        do_reset(8'd0);
        check(ovf_flags == 3'b000, "R3 reset overflow flags", 104'(ovf_flags), 104'd0);
        check(ser_out == SLBL[7], "R3 first output bit", 104'(ser_out), 104'(SLBL[7]));
        out_run = 1'b1;
        wait_blocks(4);
        for (int k = 0; k < 4; k++)
            check(cap[k] == SYNC_BLK, "R3 R2 idle stream is sync", cap[k], SYNC_BLK);

        // T2: priority when sources become ready together
        do_reset(8'd0);
        feed(3'b010, 0, 1, 2);
        repeat (150) @(negedge clk);
        feed(3'b101, 0, 1, 2);
        repeat (150) @(negedge clk);
        out_run = 1'b1;
        wait_blocks(5);
        check(cap[0] == SYNC_BLK, "R3 block 0 sync", cap[0], SYNC_BLK);
        check(cap[1] == SYNC_BLK, "R7 filler sync", cap[1], SYNC_BLK);
        check(cap[2] == {L2, exp_pay(1, 0)}, "R1 source 2 block", cap[2], {L2, exp_pay(1, 0)});
        check(cap[3] == {L1, exp_pay(0, 0)}, "R5 source 1 before 3", cap[3], {L1, exp_pay(0, 0)});
        check(cap[4] == {L3, exp_pay(2, 0)}, "R5 source 3 last", cap[4], {L3, exp_pay(2, 0)});
        check(ovf_flags == 3'b000, "R9 no overflow", 104'(ovf_flags), 104'd0);

        // T3: all sources streaming, output running
        do_reset(8'd0);
        out_run = 1'b1;
        feed(3'b111, 0, 4, 8);
        wait_blocks(26);
        analyse(4, 0);
        check(ovf_flags == 3'b000, "R4 no overflow in stream", 104'(ovf_flags), 104'd0);

        // T4: forced sync interval of 3
        do_reset(8'd3);
        out_run = 1'b1;
        feed(3'b111, 0, 2, 8);
        wait_blocks(15);
        analyse(2, 3);

        // T5: overflow on source 3 with output stalled
        do_reset(8'd0);
        feed(3'b100, 0, 3, 2);
        repeat (20) @(negedge clk);
        check(ovf_flags == 3'b100, "R9 overflow source 3 only", 104'(ovf_flags), 104'b100);
        repeat (300) @(negedge clk);
        check(ovf_flags == 3'b100, "R9 overflow sticky", 104'(ovf_flags), 104'b100);
        out_run = 1'b1;
        wait_blocks(5);
        check(cap[2] == {L3, exp_pay(2, 0)}, "R9 first kept block", cap[2], {L3, exp_pay(2, 0)});
        check(cap[3] == {L3, exp_pay(2, 1)}, "R9 second kept block", cap[3], {L3, exp_pay(2, 1)});
        check(cap[4] == SYNC_BLK, "R9 third block dropped", cap[4], SYNC_BLK);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule